// File: doc/BRIEF.md
# Programmable field vertical sync generator

This block produces the vertical sync pulse for an interlaced 525-line video stream. It also produces a vertical-blanking flag that follows the pulse exactly and is meant for the logic that builds embedded timing reference codes. An upstream timing chain supplies three inputs each clock: the line number within the current field, the horizontal sample count within the line, and a flag that is high during odd fields. Line counting and generating the reference codes are outside this block.

The start edge and the end edge of the pulse each have their own settings. Each edge has a 5-bit whole-line offset from a nominal line, and a sign that chooses whether the offset moves the edge later or earlier. For each field parity, an edge can also take one extra line of delay, or be advanced by half a line.

Settings arrive through a small write port. They are held as pending values and copied into the working set only at the first sample of a field, so a pulse is never built from two different settings. Positions are compared in half-line units. The output is high from the computed start position up to, but not including, the computed end position.

Top module: `vsync_field_gen`

## Requirements
- R1: After reset the start edge uses offset 5 in the advance direction and the end edge uses offset 0 in the delay direction, with every per-field bit clear. The pulse therefore spans from sample 0 of line NOM_BEGIN_LINE-5 to sample 0 of line NOM_END_LINE, and both outputs are low while reset is held.
- R2: `wr_addr_i` = 0 writes the start-edge settings and 1 writes the end-edge settings. In `wr_data_i`, bits [4:0] hold the offset and bit [5] the sign. With the sign at 0 the edge line is the nominal line plus the offset; with the sign at 1 it is the nominal line minus the offset.
- R3: For the start edge, `wr_data_i[6]` adds one line of delay in odd fields and `wr_data_i[7]` adds one line of delay in even fields. A field is odd when `field_odd_i` is 1.
- R4: For the end edge, the same two bits add one line of delay before the pulse falls, in odd and in even fields respectively.
- R5: `wr_data_i[8]` (odd fields) and `wr_data_i[9]` (even fields) advance that edge by half a line. The edge then fires at horizontal count H_TOTAL/2 on the line before the computed edge line, instead of at count 0 on the edge line.
- R6: `vsync_o` and `vblank_o` are equal in every cycle.
- R7: Written settings, and the field parity, take effect only at a field start, which is a cycle with line 0 and horizontal count 0. Until then the earlier settings stay in force.
- R8: When the computed end position is at or before the computed start position, neither output is asserted during that field.
- R9: The outputs are registered. They reflect the line and horizontal count presented one clock earlier, and they are high for positions at or after the start and before the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | LINE_W | Line number within the current field |
| hcount_i | input | H_W | Horizontal sample count within the line |
| field_odd_i | input | 1 | High during odd fields; sampled at field start |
| wr_en_i | input | 1 | Write strobe for the settings |
| wr_addr_i | input | 1 | 0 selects the start edge, 1 selects the end edge |
| wr_data_i | input | 10 | Setting word, laid out as in R2 to R5 |
| vsync_o | output | 1 | Vertical sync pulse |
| vblank_o | output | 1 | Vertical-blanking flag for reference codes |

## Verification
Each output is due one clock after the line and horizontal count that produce it. A setting is due only after both a write clock and a field-start clock have passed. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. To check the latency, it also samples the output just before the rising edge and expects the old value there. For each edge, probes sit on the last position before the edge and on the first position at it. This covers the sign, the extra-line bits, the half-line bits and the field parity. One directed sequence writes a new setting in mid-field and checks that the output does not change before the next field start.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int OFFSET_W = 5;
    localparam int EDGE_N   = 2;
    localparam int CFG_W    = OFFSET_W + 5;

    // Setting word of one edge; the last member lands in the low bits.
    typedef struct packed {
        logic                half_even;
        logic                half_odd;
        logic                extra_even;
        logic                extra_odd;
        logic                advance;
        logic [OFFSET_W-1:0] offset;
    } edge_cfg_t;

    localparam edge_cfg_t BEGIN_RST = '{half_even: 1'b0, half_odd: 1'b0,
                                        extra_even: 1'b0, extra_odd: 1'b0,
                                        advance: 1'b1, offset: 5'd5};
    localparam edge_cfg_t END_RST   = '{half_even: 1'b0, half_odd: 1'b0,
                                        extra_even: 1'b0, extra_odd: 1'b0,
                                        advance: 1'b0, offset: 5'd0};

endpackage

// File: rtl/vsg_cfg_regs.sv
module vsg_cfg_regs
    import vsg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic                      wr_addr_i,
    input  logic [CFG_W-1:0]          wr_data_i,
    input  logic                      field_start_i,
    input  logic                      field_odd_i,
    output edge_cfg_t [EDGE_N-1:0]    act_cfg_o,
    output logic                      act_odd_o
);

    typedef struct packed {
        edge_cfg_t [EDGE_N-1:0] pend;
        edge_cfg_t [EDGE_N-1:0] act;
        logic                   odd;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.pend[wr_addr_i] = edge_cfg_t'(wr_data_i);
        end
        // Working set and parity change only on the first sample of a field.
        if (field_start_i) begin
            state_d.act = state_q.pend;
            state_d.odd = field_odd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pend[0] <= BEGIN_RST;
            state_q.pend[1] <= END_RST;
            state_q.act[0]  <= BEGIN_RST;
            state_q.act[1]  <= END_RST;
            state_q.odd     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_cfg_o = state_q.act;
    assign act_odd_o = state_q.odd;

    // R7: no change to the working set between field starts.
    p_hold_mid_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start_i |=> ($stable(state_q.act) && $stable(state_q.odd)));

endmodule

// File: rtl/vsg_edge_pos.sv
module vsg_edge_pos
    import vsg_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int NOM_LINE = 8,
    localparam int POS_W   = LINE_W + 3
) (
    input  edge_cfg_t               cfg_i,
    input  logic                    odd_i,
    output logic signed [POS_W-1:0] pos_o
);

    logic signed [POS_W-1:0] nom_s;
    logic signed [POS_W-1:0] off_s;
    logic signed [POS_W-1:0] line_s;
    logic                    extra;
    logic                    half;

    assign nom_s = $signed(POS_W'(NOM_LINE));
    assign off_s = $signed({{(POS_W-OFFSET_W){1'b0}}, cfg_i.offset});

    always_comb begin
        extra  = odd_i ? cfg_i.extra_odd : cfg_i.extra_even;
        half   = odd_i ? cfg_i.half_odd  : cfg_i.half_even;
        line_s = nom_s + (cfg_i.advance ? -off_s : off_s)
               + $signed({{(POS_W-1){1'b0}}, extra});
        // Position in half-line units; a half-line advance takes one unit off.
        pos_o  = (line_s <<< 1) - $signed({{(POS_W-1){1'b0}}, half});
    end

endmodule

// File: rtl/vsg_pulse_stage.sv
module vsg_pulse_stage #(
    parameter int POS_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [POS_W-1:0] cur_pos_i,
    input  logic signed [POS_W-1:0] beg_pos_i,
    input  logic signed [POS_W-1:0] end_pos_i,
    output logic                    vsync_o,
    output logic                    vblank_o
);

    typedef struct packed {
        logic vsync;
        logic vblank;
    } pulse_state_t;

    pulse_state_t state_d, state_q;
    logic         in_window;

    always_comb begin
        in_window      = (end_pos_i > beg_pos_i) &&
                         (cur_pos_i >= beg_pos_i) && (cur_pos_i < end_pos_i);
        state_d.vsync  = in_window;
        state_d.vblank = in_window;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vsync_o  = state_q.vsync;
    assign vblank_o = state_q.vblank;

    // R6: both outputs always agree.
    p_outputs_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o == vblank_o);

    // R8: empty window gives no pulse.
    p_suppress_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pos_i <= beg_pos_i) |=> !vsync_o);

    // R9: nothing before the start position.
    p_quiet_before_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pos_i < beg_pos_i) |=> !vsync_o);

    // R9: a rise always follows a position inside the window.
    p_rise_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> ($past(cur_pos_i) >= $past(beg_pos_i)));

endmodule

// File: rtl/vsync_field_gen.sv
module vsync_field_gen
    import vsg_pkg::*;
#(
    parameter int LINE_W         = 10,
    parameter int H_W            = 10,
    parameter int H_TOTAL        = 858,
    parameter int NOM_BEGIN_LINE = 8,
    parameter int NOM_END_LINE   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_i,
    input  logic [H_W-1:0]    hcount_i,
    input  logic              field_odd_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    output logic              vsync_o,
    output logic              vblank_o
);

    localparam int POS_W = LINE_W + 3;
    localparam int HALF  = H_TOTAL / 2;

    edge_cfg_t [EDGE_N-1:0]  act_cfg;
    logic                    act_odd;
    logic                    field_start;
    logic                    second_half;
    logic signed [POS_W-1:0] cur_pos;
    logic signed [POS_W-1:0] edge_pos [EDGE_N];

    assign field_start = (line_i == '0) && (hcount_i == '0);
    assign second_half = (hcount_i >= H_W'(HALF));
    assign cur_pos     = $signed({2'b00, line_i, second_half});

    vsg_cfg_regs i_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .field_start_i (field_start),
        .field_odd_i   (field_odd_i),
        .act_cfg_o     (act_cfg),
        .act_odd_o     (act_odd)
    );

    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        vsg_edge_pos #(
            .LINE_W   (LINE_W),
            .NOM_LINE ((g == 0) ? NOM_BEGIN_LINE : NOM_END_LINE)
        ) i_pos (
            .cfg_i (act_cfg[g]),
            .odd_i (act_odd),
            .pos_o (edge_pos[g])
        );
    end

    vsg_pulse_stage #(.POS_W(POS_W)) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_pos_i (cur_pos),
        .beg_pos_i (edge_pos[0]),
        .end_pos_i (edge_pos[1]),
        .vsync_o   (vsync_o),
        .vblank_o  (vblank_o)
    );

endmodule

// File: tb/test_vsync_field_gen.sv
module test_vsync_field_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] line;
    logic [9:0] hcount;
    logic       field_odd;
    logic       wr_en;
    logic       wr_addr;
    logic [9:0] wr_data;
    logic       vsync;
    logic       vblank;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vsync_field_gen i_vsync_field_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .hcount_i    (hcount),
        .field_odd_i (field_odd),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .vsync_o     (vsync),
        .vblank_o    (vblank)
    );

    // Defaults: nominal start line 8, nominal end line 14, half line at 429.
    typedef struct packed {
        logic [9:0] beg;
        logic [9:0] endc;
        logic       odd;
        logic [9:0] ln;
        logic [9:0] h;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{10'h025, 10'h000, 1'b1, 10'd2,  10'd857, 1'b0, 4'd1}, // R1 start at line 3
        '{10'h025, 10'h000, 1'b1, 10'd3,  10'd0,   1'b1, 4'd1}, // R1
        '{10'h025, 10'h000, 1'b1, 10'd13, 10'd857, 1'b1, 4'd1}, // R1
        '{10'h025, 10'h000, 1'b1, 10'd14, 10'd0,   1'b0, 4'd1}, // R1 end at line 14
        '{10'h003, 10'h000, 1'b1, 10'd10, 10'd857, 1'b0, 4'd2}, // R2 delay start to 11
        '{10'h003, 10'h000, 1'b1, 10'd11, 10'd0,   1'b1, 4'd2}, // R2
        '{10'h025, 10'h022, 1'b1, 10'd11, 10'd857, 1'b1, 4'd2}, // R2 advance end to 12
        '{10'h025, 10'h022, 1'b1, 10'd12, 10'd0,   1'b0, 4'd2}, // R2
        '{10'h065, 10'h000, 1'b1, 10'd3,  10'd857, 1'b0, 4'd3}, // R3 odd extra line
        '{10'h065, 10'h000, 1'b1, 10'd4,  10'd0,   1'b1, 4'd3}, // R3
        '{10'h065, 10'h000, 1'b0, 10'd3,  10'd0,   1'b1, 4'd3}, // R3 odd bit idle in even
        '{10'h0A5, 10'h000, 1'b0, 10'd3,  10'd857, 1'b0, 4'd3}, // R3 even extra line
        '{10'h0A5, 10'h000, 1'b0, 10'd4,  10'd0,   1'b1, 4'd3}, // R3
        '{10'h025, 10'h040, 1'b1, 10'd14, 10'd0,   1'b1, 4'd4}, // R4 odd end to 15
        '{10'h025, 10'h040, 1'b1, 10'd15, 10'd0,   1'b0, 4'd4}, // R4
        '{10'h025, 10'h040, 1'b0, 10'd14, 10'd0,   1'b0, 4'd4}, // R4 odd bit idle in even
        '{10'h025, 10'h080, 1'b0, 10'd14, 10'd857, 1'b1, 4'd4}, // R4 even end to 15
        '{10'h125, 10'h000, 1'b1, 10'd2,  10'd429, 1'b1, 4'd5}, // R5 start half early
        '{10'h125, 10'h000, 1'b1, 10'd2,  10'd428, 1'b0, 4'd5}, // R5
        '{10'h125, 10'h000, 1'b0, 10'd2,  10'd429, 1'b0, 4'd5}, // R5 odd bit idle in even
        '{10'h225, 10'h000, 1'b0, 10'd2,  10'd429, 1'b1, 4'd5}, // R5 even start half
        '{10'h025, 10'h100, 1'b1, 10'd13, 10'd429, 1'b0, 4'd5}, // R5 end half early
        '{10'h025, 10'h100, 1'b1, 10'd13, 10'd428, 1'b1, 4'd5}, // R5
        '{10'h025, 10'h200, 1'b1, 10'd13, 10'd429, 1'b1, 4'd5}, // R5 even bit idle in odd
        '{10'h003, 10'h026, 1'b1, 10'd9,  10'd0,   1'b0, 4'd8}, // R8 end 8 before start 11
        '{10'h003, 10'h026, 1'b1, 10'd11, 10'd0,   1'b0, 4'd8}  // R8
    };

    task automatic check(input int req, input logic exp, input string what);
        checks++;
        if (vsync !== exp || vblank !== exp) begin
            errors++;
            $display("FAIL R%0d %s: vsync=%b vblank=%b expected %b",
                     req, what, vsync, vblank, exp);
        end
    endtask

    task automatic write_cfg(input logic a, input logic [9:0] d);
        @(negedge clk);
        line = 10'd100; hcount = 10'd5;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_field(input logic odd);
        @(negedge clk);
        line = 10'd0; hcount = 10'd0; field_odd = odd;
        @(negedge clk);
    endtask

    // Called at a falling edge: drive, let one rising edge pass, sample.
    task automatic probe(input logic [9:0] ln, input logic [9:0] h);
        line = ln; hcount = h;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog: run hung, cycles=%0d expected under 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; line = '0; hcount = '0; field_odd = 1'b1;
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(1, 1'b0, "outputs low in reset");    // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, "low at field start after reset");   // R1
        probe(10'd3, 10'd0);
        check(1, 1'b1, "reset start edge at line 3");      // R1

        for (int i = 0; i < NV; i++) begin
            write_cfg(1'b0, VECS[i].beg);
            write_cfg(1'b1, VECS[i].endc);
            start_field(VECS[i].odd);
            probe(VECS[i].ln, VECS[i].h);
            check(int'(VECS[i].req), VECS[i].exp, $sformatf("vector %0d", i));
        end

        // R7: a mid-field write must wait for the next field start.
        write_cfg(1'b0, 10'h025);
        write_cfg(1'b1, 10'h000);
        start_field(1'b1);
        write_cfg(1'b0, 10'h003);
        probe(10'd5, 10'd0);
        check(7, 1'b1, "old start kept mid-field");
        start_field(1'b1);
        probe(10'd5, 10'd0);
        check(7, 1'b0, "new start after field start");
        probe(10'd11, 10'd0);
        check(7, 1'b1, "new start line 11 active");

        // R7: parity is taken at field start, not mid-field.
        write_cfg(1'b0, 10'h065);
        start_field(1'b0);
        field_odd = 1'b1;
        probe(10'd3, 10'd0);
        check(7, 1'b1, "parity held from field start");

        // R9: one clock of latency.
        write_cfg(1'b0, 10'h025);
        start_field(1'b1);
        probe(10'd2, 10'd0);
        line = 10'd3;
        #5;
        check(9, 1'b0, "old value before rising edge");
        @(negedge clk);
        check(9, 1'b1, "new value one clock later");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule